// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block carries out the architectural state changes that happen when a hart with machine and supervisor privilege levels takes a trap. A trap request arrives as a single-beat transfer carrying an interrupt flag, a cause code, the faulting address and the PC of the trapping instruction. In the cycle of acceptance the block picks the handling level from the current privilege and the delegation masks. It then saves the interrupt-enable and previous-privilege state, and writes the cause, return-PC and trap-value registers of the chosen level. After that edge it presents a one-cycle redirect carrying the handler address.

Configuration state is loaded through a plain write port. That state covers the status enables, both delegation masks, both vector registers and the current privilege. Each target is picked by a 3-bit select: 0 status, 1 exception delegation, 2 interrupt delegation, 3 supervisor vector, 4 machine vector, 5 privilege. The trap request uses valid/ready. `trap_ready` is high in every cycle except one in which a configuration write is presented. A request is taken only on an edge where both `trap_valid` and `trap_ready` are high. A request held off by back-pressure leaves no trace and must be held by the sender.

Top module: `trap_entry_ctrl`

## Requirements
- R1: A trap is handled at supervisor level only when the current privilege is user (0) or supervisor (1) and the bit indexed by the final cause code is set. That bit is read from the interrupt delegation mask for interrupts and from the exception delegation mask for exceptions. Every other trap, including any trap taken at machine privilege (3), is handled at machine level.
- R2: On supervisor entry the status word changes as follows: bit 5 takes the old bit 1, bit 8 takes bit 0 of the old privilege, and bit 1 is cleared. The supervisor return-PC takes `trap_pc` and the privilege becomes 1. Machine-level registers are untouched.
- R3: On machine entry the status word changes as follows: bit 7 takes the old bit 3, bits 12:11 take the old privilege, and bit 3 is cleared. The machine return-PC takes `trap_pc` and the privilege becomes 3.
- R4: The cause register of the handling level receives the final cause code in its low bits, with bit XLEN-1 set for an interrupt and clear for an exception.
- R5: The redirect address is the handling level's vector register with bits 1:0 forced to zero. When those two bits equal 01 and the trap is an interrupt, four times the cause code is added. Every other mode value gives the base alone.
- R6: An exception with cause 8 is recoded by the privilege at trap time: user gives 8, supervisor gives 9, machine gives 11. The recoded value is used for delegation and for the cause register. Interrupt cause 8 is not recoded.
- R7: The trap-value register of the handling level receives `trap_addr` only for exceptions with causes 0, 1, 4, 5, 6, 7, 12, 13 or 15. For every other exception and for every interrupt it receives zero.
- R8: A configuration write of privilege value 2 sets the privilege to user (0). Values 0, 1 and 3 are taken as written.
- R9: One cycle after each accepted trap, `redirect_valid` is high for exactly one cycle with the handler address on `redirect_pc`. In every other cycle it is low.
- R10: After reset the privilege is machine (3), the status word and both delegation masks are zero, `redirect_valid` is low and `trap_ready` is high.
- R11: While `cfg_we` is high, `trap_ready` is low. A request presented then changes no trap state and produces no redirect, but the configuration write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | Trap request present |
| trap_ready | output | 1 | Block can accept a trap this cycle |
| trap_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause | input | CAUSE_W | Raw cause code |
| trap_addr | input | XLEN | Faulting address |
| trap_pc | input | XLEN | PC of the trapping instruction |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target select |
| cfg_wdata | input | XLEN | Configuration write data |
| redirect_valid | output | 1 | One-cycle redirect pulse |
| redirect_pc | output | XLEN | Handler address |
| cur_priv | output | 2 | Current privilege |
| status_o | output | XLEN | Status word |
| s_cause_o | output | XLEN | Supervisor cause register |
| s_epc_o | output | XLEN | Supervisor return-PC |
| s_tval_o | output | XLEN | Supervisor trap value |
| m_cause_o | output | XLEN | Machine cause register |
| m_epc_o | output | XLEN | Machine return-PC |
| m_tval_o | output | XLEN | Machine trap value |

## Verification
The assertions assume that the request fields are stable and known whenever `trap_valid` is high. They also assume that an interrupt cause fits below XLEN, so the delegation lookup never leaves the mask. The stimulus meets both conditions by changing inputs only on the falling clock edge and by using cause codes below 16. It also loads the status word and privilege through the write port before every request, so the saved-enable and previous-privilege checks start from a known value. Back-pressure is exercised by presenting a write and a request on the same edge.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_EDELEG = 3'd1,
    SEL_IDELEG = 3'd2,
    SEL_STVEC  = 3'd3,
    SEL_MTVEC  = 3'd4,
    SEL_PRIV   = 3'd5
  } cfg_sel_e;

  typedef struct packed {
    logic [1:0] mpp;
    logic       spp;
    logic       mpie;
    logic       spie;
    logic       mie;
    logic       sie;
  } stat_t;

  // bit positions of the status word, decoded by software
  localparam int ST_SIE    = 1;
  localparam int ST_MIE    = 3;
  localparam int ST_SPIE   = 5;
  localparam int ST_MPIE   = 7;
  localparam int ST_SPP    = 8;
  localparam int ST_MPP_LO = 11;

  localparam int unsigned CODE_ECALL_U = 8;
  localparam int unsigned CODE_ECALL_S = 9;
  localparam int unsigned CODE_ECALL_M = 11;

  // exceptions that report the offending address
  function automatic logic carries_addr(input int unsigned code);
    case (code)
      0, 1, 4, 5, 6, 7, 12, 13, 15: carries_addr = 1'b1;
      default:                      carries_addr = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = $clog2(XLEN)
) (
  input  logic               irq,
  input  logic [CAUSE_W-1:0] cause_raw,
  input  priv_e              priv,
  input  logic [XLEN-1:0]    edeleg,
  input  logic [XLEN-1:0]    ideleg,
  output logic [CAUSE_W-1:0] cause_eff,
  output logic               to_super,
  output logic               keep_addr
);

  logic [XLEN-1:0] mask_sel;
  logic            low_priv;

  always_comb begin
    cause_eff = cause_raw;
    if (!irq && cause_raw == CAUSE_W'(CODE_ECALL_U)) begin
      case (priv)
        PRIV_S:  cause_eff = CAUSE_W'(CODE_ECALL_S);
        PRIV_M:  cause_eff = CAUSE_W'(CODE_ECALL_M);
        default: cause_eff = CAUSE_W'(CODE_ECALL_U);
      endcase
    end
  end

  always_comb begin
    mask_sel  = irq ? ideleg : edeleg;
    low_priv  = (priv == PRIV_U) || (priv == PRIV_S);
    to_super  = low_priv && mask_sel[cause_eff];
    keep_addr = !irq && carries_addr(32'(cause_eff));
  end

endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]    tvec,
  input  logic               irq,
  input  logic [CAUSE_W-1:0] cause,
  output logic [XLEN-1:0]    target_pc
);

  localparam logic [1:0] MODE_VECTORED = 2'b01;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    base      = {tvec[XLEN-1:2], 2'b00};
    offset    = (irq && tvec[1:0] == MODE_VECTORED) ? (XLEN'(cause) << 2) : '0;
    target_pc = base + offset;
  end

endmodule

// File: rtl/trap_state.sv
module trap_state
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = $clog2(XLEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [XLEN-1:0]    cfg_wdata,
  input  logic               to_super,
  input  logic               irq,
  input  logic [CAUSE_W-1:0] cause_eff,
  input  logic               keep_addr,
  input  logic [XLEN-1:0]    fault_addr,
  input  logic [XLEN-1:0]    cur_pc,
  output priv_e              priv_q,
  output logic [XLEN-1:0]    status_o,
  output logic [XLEN-1:0]    edeleg_q,
  output logic [XLEN-1:0]    ideleg_q,
  output logic [XLEN-1:0]    stvec_q,
  output logic [XLEN-1:0]    mtvec_q,
  output logic [XLEN-1:0]    scause_q,
  output logic [XLEN-1:0]    sepc_q,
  output logic [XLEN-1:0]    stval_q,
  output logic [XLEN-1:0]    mcause_q,
  output logic [XLEN-1:0]    mepc_q,
  output logic [XLEN-1:0]    mtval_q
);

  localparam int PAD_W = XLEN - 1 - CAUSE_W;

  stat_t           stat_q;
  logic [XLEN-1:0] cause_word;
  logic [XLEN-1:0] tval_word;
  cfg_sel_e        sel;

  assign sel        = cfg_sel_e'(cfg_sel);
  assign cause_word = {irq, {PAD_W{1'b0}}, cause_eff};
  assign tval_word  = keep_addr ? fault_addr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q   <= PRIV_M;
      stat_q   <= '0;
      edeleg_q <= '0;
      ideleg_q <= '0;
      stvec_q  <= '0;
      mtvec_q  <= '0;
      scause_q <= '0;
      sepc_q   <= '0;
      stval_q  <= '0;
      mcause_q <= '0;
      mepc_q   <= '0;
      mtval_q  <= '0;
    end else if (cfg_we) begin
      case (sel)
        SEL_STATUS: begin
          stat_q.sie  <= cfg_wdata[ST_SIE];
          stat_q.mie  <= cfg_wdata[ST_MIE];
          stat_q.spie <= cfg_wdata[ST_SPIE];
          stat_q.mpie <= cfg_wdata[ST_MPIE];
          stat_q.spp  <= cfg_wdata[ST_SPP];
          stat_q.mpp  <= cfg_wdata[ST_MPP_LO +: 2];
        end
        SEL_EDELEG: edeleg_q <= cfg_wdata;
        SEL_IDELEG: ideleg_q <= cfg_wdata;
        SEL_STVEC:  stvec_q  <= cfg_wdata;
        SEL_MTVEC:  mtvec_q  <= cfg_wdata;
        SEL_PRIV:   priv_q   <= (cfg_wdata[1:0] == 2'd2) ? PRIV_U : priv_e'(cfg_wdata[1:0]);
        default: ;
      endcase
    end else if (take) begin
      if (to_super) begin
        stat_q.spie <= stat_q.sie;
        stat_q.spp  <= priv_q[0];
        stat_q.sie  <= 1'b0;
        scause_q    <= cause_word;
        sepc_q      <= cur_pc;
        stval_q     <= tval_word;
        priv_q      <= PRIV_S;
      end else begin
        stat_q.mpie <= stat_q.mie;
        stat_q.mpp  <= priv_q;
        stat_q.mie  <= 1'b0;
        mcause_q    <= cause_word;
        mepc_q      <= cur_pc;
        mtval_q     <= tval_word;
        priv_q      <= PRIV_M;
      end
    end
  end

  always_comb begin
    status_o                  = '0;
    status_o[ST_SIE]          = stat_q.sie;
    status_o[ST_MIE]          = stat_q.mie;
    status_o[ST_SPIE]         = stat_q.spie;
    status_o[ST_MPIE]         = stat_q.mpie;
    status_o[ST_SPP]          = stat_q.spp;
    status_o[ST_MPP_LO +: 2]  = stat_q.mpp;
  end

  a_r1_machine_keeps_machine: assert property (@(posedge clk) disable iff (!rst_n)
    (take && priv_q == PRIV_M) |=> (priv_q == PRIV_M));

  a_r2_super_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (take && to_super) |=> (priv_q == PRIV_S && !stat_q.sie &&
      stat_q.spie == $past(stat_q.sie) && sepc_q == $past(cur_pc)));

  a_r3_machine_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !to_super) |=> (priv_q == PRIV_M && !stat_q.mie &&
      stat_q.mpie == $past(stat_q.mie) && stat_q.mpp == $past(priv_q) &&
      mepc_q == $past(cur_pc)));

  a_r4_irq_flag_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !to_super) |=> (mcause_q[XLEN-1] == $past(irq)));

  a_r7_irq_no_tval_s: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq && to_super) |=> (stval_q == '0));

  a_r7_irq_no_tval_m: assert property (@(posedge clk) disable iff (!rst_n)
    (take && irq && !to_super) |=> (mtval_q == '0));

  a_r8_priv_never_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    priv_q != PRIV_RSVD);

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = $clog2(XLEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_valid,
  output logic               trap_ready,
  input  logic               trap_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_addr,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [XLEN-1:0]    cfg_wdata,
  output logic               redirect_valid,
  output logic [XLEN-1:0]    redirect_pc,
  output logic [1:0]         cur_priv,
  output logic [XLEN-1:0]    status_o,
  output logic [XLEN-1:0]    s_cause_o,
  output logic [XLEN-1:0]    s_epc_o,
  output logic [XLEN-1:0]    s_tval_o,
  output logic [XLEN-1:0]    m_cause_o,
  output logic [XLEN-1:0]    m_epc_o,
  output logic [XLEN-1:0]    m_tval_o
);

  priv_e              priv_q;
  logic [XLEN-1:0]    edeleg_q, ideleg_q, stvec_q, mtvec_q;
  logic [CAUSE_W-1:0] cause_eff;
  logic               to_super;
  logic               keep_addr;
  logic               take;
  logic [XLEN-1:0]    tvec_sel;
  logic [XLEN-1:0]    target_pc;
  logic               redir_q;
  logic [XLEN-1:0]    redir_pc_q;

  assign trap_ready = !cfg_we;
  assign take       = trap_valid && trap_ready;
  assign tvec_sel   = to_super ? stvec_q : mtvec_q;

  trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
    .irq       (trap_irq),
    .cause_raw (trap_cause),
    .priv      (priv_q),
    .edeleg    (edeleg_q),
    .ideleg    (ideleg_q),
    .cause_eff (cause_eff),
    .to_super  (to_super),
    .keep_addr (keep_addr)
  );

  trap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vector (
    .tvec      (tvec_sel),
    .irq       (trap_irq),
    .cause     (cause_eff),
    .target_pc (target_pc)
  );

  trap_state #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .to_super   (to_super),
    .irq        (trap_irq),
    .cause_eff  (cause_eff),
    .keep_addr  (keep_addr),
    .fault_addr (trap_addr),
    .cur_pc     (trap_pc),
    .priv_q     (priv_q),
    .status_o   (status_o),
    .edeleg_q   (edeleg_q),
    .ideleg_q   (ideleg_q),
    .stvec_q    (stvec_q),
    .mtvec_q    (mtvec_q),
    .scause_q   (s_cause_o),
    .sepc_q     (s_epc_o),
    .stval_q    (s_tval_o),
    .mcause_q   (m_cause_o),
    .mepc_q     (m_epc_o),
    .mtval_q    (m_tval_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_q    <= 1'b0;
      redir_pc_q <= '0;
    end else begin
      redir_q <= take;
      if (take) redir_pc_q <= target_pc;
    end
  end

  assign redirect_valid = redir_q;
  assign redirect_pc    = redir_pc_q;
  assign cur_priv       = priv_q;

  a_r9_redirect_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && trap_ready) |=> redirect_valid);

  a_r9_redirect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_valid && trap_ready) |=> !redirect_valid);

  a_r11_held_off_keeps_epc: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !trap_ready) |=> ($stable(m_epc_o) && $stable(s_epc_o)));

endmodule

// File: tb/trap_entry_ctrl_bench.sv
module trap_entry_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 32;
  localparam int CW         = 5;
  localparam int NVEC       = 12;

  typedef struct packed {
    logic [1:0]  priv;
    logic        irq;
    logic [4:0]  cause;
    logic [31:0] addr;
    logic [31:0] pc;
    logic        to_s;
    logic [31:0] exp_cause;
    logic [31:0] exp_pc;
    logic        tval_addr;
  } vec_t;

  // stvec = 0x1001 (vectored), mtvec = 0x8003 (direct), edeleg bits 8,13,15, ideleg bits 5,9
  localparam vec_t VT [NVEC] = '{
    '{2'd0, 1'b0, 5'd13, 32'hDEAD0000, 32'h100, 1'b1, 32'd13,        32'h1000, 1'b1},
    '{2'd0, 1'b0, 5'd8,  32'h11110000, 32'h104, 1'b1, 32'd8,         32'h1000, 1'b0},
    '{2'd1, 1'b0, 5'd8,  32'h22220000, 32'h108, 1'b0, 32'd9,         32'h8000, 1'b0},
    '{2'd3, 1'b0, 5'd8,  32'h00003333, 32'h10C, 1'b0, 32'd11,        32'h8000, 1'b0},
    '{2'd1, 1'b1, 5'd5,  32'h00004444, 32'h110, 1'b1, 32'h80000005, 32'h1014, 1'b0},
    '{2'd3, 1'b1, 5'd5,  32'h00005555, 32'h114, 1'b0, 32'h80000005, 32'h8000, 1'b0},
    '{2'd0, 1'b1, 5'd7,  32'h00006666, 32'h118, 1'b0, 32'h80000007, 32'h8000, 1'b0},
    '{2'd1, 1'b0, 5'd2,  32'h00007777, 32'h11C, 1'b0, 32'd2,         32'h8000, 1'b0},
    '{2'd0, 1'b0, 5'd15, 32'h00008888, 32'h120, 1'b1, 32'd15,        32'h1000, 1'b1},
    '{2'd0, 1'b0, 5'd4,  32'h00009999, 32'h124, 1'b0, 32'd4,         32'h8000, 1'b1},
    '{2'd1, 1'b1, 5'd9,  32'h0000AAAA, 32'h128, 1'b1, 32'h80000009, 32'h1024, 1'b0},
    '{2'd3, 1'b0, 5'd13, 32'h0000BBBB, 32'h12C, 1'b0, 32'd13,        32'h8000, 1'b1}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            trap_valid = 1'b0;
  logic            trap_ready;
  logic            trap_irq = 1'b0;
  logic [CW-1:0]   trap_cause = '0;
  logic [XLEN-1:0] trap_addr = '0;
  logic [XLEN-1:0] trap_pc = '0;
  logic            cfg_we = 1'b0;
  logic [2:0]      cfg_sel = '0;
  logic [XLEN-1:0] cfg_wdata = '0;
  logic            redirect_valid;
  logic [XLEN-1:0] redirect_pc;
  logic [1:0]      cur_priv;
  logic [XLEN-1:0] status_o, s_cause_o, s_epc_o, s_tval_o, m_cause_o, m_epc_o, m_tval_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CW)) u_trap_entry_ctrl (
    .clk, .rst_n, .trap_valid, .trap_ready, .trap_irq, .trap_cause, .trap_addr,
    .trap_pc, .cfg_we, .cfg_sel, .cfg_wdata, .redirect_valid, .redirect_pc,
    .cur_priv, .status_o, .s_cause_o, .s_epc_o, .s_tval_o, .m_cause_o,
    .m_epc_o, .m_tval_o
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire(input logic irq, input logic [4:0] cause,
                      input logic [31:0] addr, input logic [31:0] pc);
    @(negedge clk);
    trap_valid = 1'b1; trap_irq = irq; trap_cause = cause;
    trap_addr = addr; trap_pc = pc;
    @(negedge clk);
    trap_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 priv", 32'(cur_priv), 32'd3);
    check("R10 status", status_o, 32'h0);
    check("R10 redirect", 32'(redirect_valid), 32'd0);
    check("R10 ready", 32'(trap_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 priv after release", 32'(cur_priv), 32'd3);

    cfg_write(3'd3, 32'h1001);
    cfg_write(3'd4, 32'h8003);
    cfg_write(3'd1, 32'h0000A100);
    cfg_write(3'd2, 32'h00000220);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] exp_stat;
      logic [31:0] exp_tval;
      cfg_write(3'd0, 32'h0000000A);
      cfg_write(3'd5, 32'(VT[i].priv));
      fire(VT[i].irq, VT[i].cause, VT[i].addr, VT[i].pc);
      exp_tval = VT[i].tval_addr ? VT[i].addr : 32'h0;
      check($sformatf("R9 vec%0d redirect", i), 32'(redirect_valid), 32'd1);
      check($sformatf("R5 vec%0d pc", i), redirect_pc, VT[i].exp_pc);
      check($sformatf("R1 vec%0d priv", i), 32'(cur_priv), VT[i].to_s ? 32'd1 : 32'd3);
      if (VT[i].to_s) begin
        exp_stat = 32'h8 | 32'h20 | (32'(VT[i].priv[0]) << 8);
        check($sformatf("R2 vec%0d status", i), status_o, exp_stat);
        check($sformatf("R2 vec%0d sepc", i), s_epc_o, VT[i].pc);
        check($sformatf("R4 R6 vec%0d scause", i), s_cause_o, VT[i].exp_cause);
        check($sformatf("R7 vec%0d stval", i), s_tval_o, exp_tval);
      end else begin
        exp_stat = 32'h2 | 32'h80 | (32'(VT[i].priv) << 11);
        check($sformatf("R3 vec%0d status", i), status_o, exp_stat);
        check($sformatf("R3 vec%0d mepc", i), m_epc_o, VT[i].pc);
        check($sformatf("R4 R6 vec%0d mcause", i), m_cause_o, VT[i].exp_cause);
        check($sformatf("R7 vec%0d mtval", i), m_tval_o, exp_tval);
      end
      @(negedge clk);
      check($sformatf("R9 vec%0d pulse ends", i), 32'(redirect_valid), 32'd0);
    end

    // R8: reserved privilege maps to user
    cfg_write(3'd5, 32'd2);
    check("R8 reserved to user", 32'(cur_priv), 32'd0);
    cfg_write(3'd5, 32'd1);
    check("R8 supervisor kept", 32'(cur_priv), 32'd1);

    // R11: write and request on the same edge
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'h0000000A;
    trap_valid = 1'b1; trap_irq = 1'b0; trap_cause = 5'd2;
    trap_addr = 32'h1234; trap_pc = 32'h0000F000;
    #1;
    check("R11 ready low", 32'(trap_ready), 32'd0);
    @(negedge clk);
    cfg_we = 1'b0; trap_valid = 1'b0;
    check("R11 no redirect", 32'(redirect_valid), 32'd0);
    check("R11 priv unchanged", 32'(cur_priv), 32'd1);
    check("R11 mepc unchanged", m_epc_o, 32'h12C);
    check("R11 write applied", status_o, 32'h0000000A);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule